// File: doc/BRIEF.md
# I2C RAM Target with Self-Advancing Word Pointer

This block is an I2C target (slave) that makes a small byte memory reachable over a two-wire bus. It runs on the system clock. SCL and SDA are resynchronised and edge-detected, and the SDA driver is open-drain: the block only ever pulls the line low or lets it go. The 7-bit bus address it answers to comes from an input port, so the surrounding logic can set it.

A bus controller writes by sending the target address with the direction bit clear. The next byte it sends is a word pointer. Every byte after that is stored at the pointer, and the pointer then advances by one. To read, the controller writes the pointer, issues a repeated start, and addresses the target again with the direction bit set. The target then sends bytes from the pointer, advancing it after each byte, until the controller answers a byte with a negative acknowledge.

The pointer wraps at the top of the memory. Start, stop and reset do not clear it. A read port on the host side shows any memory location at any time without touching the bus.

Top module: `i2c_mem_target`

## Requirements
- R1: A start condition (SDA falling while SCL is high) seen at any point, including in the middle of a byte, restarts address reception from the first bit.
- R2: The first byte after a start carries the address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). The target pulls SDA low during the ninth clock only when bits 7..1 equal `ownAddr`. On a mismatch it leaves SDA released and writes nothing until the next start or stop.
- R3: After a matching write address, the next byte is loaded into the word pointer and acknowledged.
- R4: Each further written byte is acknowledged and stored at the pointer, and the pointer then increments by one.
- R5: The pointer wraps from 2**ADDR_W-1 back to 0, for both writes and reads.
- R6: After a matching read address, the target sends the byte at the pointer MSB first, releases SDA on the ninth clock, and increments the pointer after each byte sent. The pointer set by a write survives a repeated start.
- R7: If the controller acknowledges (SDA low on the ninth clock), the next byte follows. If it does not, the target releases SDA and stays silent until the next start.
- R8: A stop condition (SDA rising while SCL is high) returns the target to idle. The pointer is kept, so a later read with no pointer byte continues from where the previous transfer left off.
- R9: The target changes its SDA drive only while SCL is low, after a falling SCL edge.
- R10: `dbgData` always shows the memory byte at `dbgAddr`.
- R11: After reset the target releases SDA and stays idle until it sees a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL level seen on the bus |
| sdaIn | input | 1 | SDA level seen on the bus |
| sdaPullLow | output | 1 | 1 = drive SDA low, 0 = release it |
| ownAddr | input | 7 | Bus address the target answers to |
| dbgAddr | input | ADDR_W | Host-side memory read address |
| dbgData | output | 8 | Memory byte at `dbgAddr` |

## Verification
Burst writes followed by repeated-start reads, with random pointers, lengths and data, are compared with a bench memory model. These show whether storage, read order and pointer advance all agree. A burst that starts at 0xFE separates correct wrapping from overflow into a wider pointer. A read that ends in a negative acknowledge and is followed by extra clocks shows whether the target truly goes quiet. A read with no pointer byte after a stop shows whether the pointer was kept. A wrong address, and a start that cuts a byte short, separate address matching and restart handling from plain byte counting.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WR,
    ST_SUB,
    ST_ACK_RX,
    ST_WDATA,
    ST_ACK_RD,
    ST_TX,
    ST_TX_ACK,
    ST_TX_RESUME,
    ST_HOLD
  } tgt_state_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic rxShift;
    logic subLoad;
    logic memWrite;
    logic addrInc;
    logic txLoad;
    logic txShift;
  } dp_ctl_t;

endpackage

// File: rtl/i2c_mem_edge.sv
module i2c_mem_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe[0] <= sclIn;
      sdaPipe[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclPipe[i] <= sclPipe[i-1];
        sdaPipe[i] <= sdaPipe[i-1];
      end
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclLvl    = sclPipe[SYNC_STAGES-1];
  assign sdaLvl    = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startSeen = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopSeen  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    startSeen,
  input  logic    stopSeen,
  input  logic    sdaLvl,
  input  logic    addrHit,
  input  logic    rwBit,
  input  logic    txMsb,
  output dp_ctl_t ctl,
  output logic    sdaPullLow
);

  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DW);

  tgt_state_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;

  always_comb begin
    stateNxt  = state;
    bitCntNxt = bitCnt;
    ctl       = '0;
    if (stopSeen) begin
      stateNxt  = ST_IDLE;
      bitCntNxt = '0;
    end else if (startSeen) begin
      stateNxt  = ST_ADDR;
      bitCntNxt = '0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (sclRise && bitCnt < BYTE_END) begin
            ctl.rxShift = 1'b1;
            bitCntNxt   = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == BYTE_END) begin
            bitCntNxt = '0;
            if (state == ST_ADDR) begin
              if (!addrHit) begin
                stateNxt = ST_HOLD;
              end else if (rwBit) begin
                stateNxt   = ST_ACK_RD;
                ctl.txLoad = 1'b1;
              end else begin
                stateNxt = ST_ACK_WR;
              end
            end else if (state == ST_SUB) begin
              ctl.subLoad = 1'b1;
              stateNxt    = ST_ACK_RX;
            end else begin
              ctl.memWrite = 1'b1;
              ctl.addrInc  = 1'b1;
              stateNxt     = ST_ACK_RX;
            end
          end
        end
        ST_ACK_WR:    if (sclFall) stateNxt = ST_SUB;
        ST_ACK_RX:    if (sclFall) stateNxt = ST_WDATA;
        ST_ACK_RD:    if (sclFall) stateNxt = ST_TX;
        ST_TX: begin
          if (sclRise) begin
            bitCntNxt = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == BYTE_END) begin
              stateNxt    = ST_TX_ACK;
              bitCntNxt   = '0;
              ctl.addrInc = 1'b1;
            end else begin
              ctl.txShift = 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            if (sdaLvl) begin
              stateNxt = ST_HOLD;
            end else begin
              stateNxt   = ST_TX_RESUME;
              ctl.txLoad = 1'b1;
            end
          end
        end
        ST_TX_RESUME: if (sclFall) stateNxt = ST_TX;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
    end
  end

  always_comb begin
    case (state)
      ST_ACK_WR, ST_ACK_RX, ST_ACK_RD: sdaPullLow = 1'b1;
      ST_TX:                           sdaPullLow = ~txMsb;
      default:                         sdaPullLow = 1'b0;
    endcase
  end

  // R1: start restarts address reception
  a_r1_start_restart: assert property (@(posedge clk) disable iff (!rstN)
    startSeen && !stopSeen |=> state == ST_ADDR && bitCnt == '0);

  // R8: stop returns to idle
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> state == ST_IDLE);

  // R2: an address acknowledge needs a datapath match
  a_r2_ack_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK_WR || state == ST_ACK_RD) && $past(state) == ST_ADDR
    |-> $past(addrHit));

  // R7: negative acknowledge silences the target
  a_r7_nack_release: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_TX_ACK && sclRise && sdaLvl && !startSeen && !stopSeen
    |=> state == ST_HOLD && !sdaPullLow);

  // R4: bit counter never runs past a byte
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BYTE_END);

endmodule

// File: rtl/i2c_mem_dp.sv
module i2c_mem_dp
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic              sdaLvl,
  input  logic [6:0]        ownAddr,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic              addrHit,
  output logic              rwBit,
  output logic              txMsb,
  output logic [DW-1:0]     dbgData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     rxByte;
  logic [DW-1:0]     txByte;
  logic [ADDR_W-1:0] wordAddr;
  logic [DW-1:0]     mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte   <= '0;
      txByte   <= '1;
      wordAddr <= '0;
    end else begin
      if (ctl.rxShift) rxByte <= {rxByte[DW-2:0], sdaLvl};
      if (ctl.subLoad)      wordAddr <= rxByte[ADDR_W-1:0];
      else if (ctl.addrInc) wordAddr <= wordAddr + 1'b1;
      if (ctl.txLoad)       txByte <= mem[wordAddr];
      else if (ctl.txShift) txByte <= {txByte[DW-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.memWrite) mem[wordAddr] <= rxByte;
  end

  assign addrHit = rxByte[DW-1:1] == ownAddr;
  assign rwBit   = rxByte[0];
  assign txMsb   = txByte[DW-1];
  assign dbgData = mem[dbgAddr];

  // R4: a written byte lands at the pointer it was aimed at
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.memWrite) |-> mem[$past(wordAddr)] == $past(rxByte));

  // R5: pointer wraps to zero
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ctl.addrInc && !ctl.subLoad && wordAddr == '1 |=> wordAddr == '0);

  // R3: pointer load and advance never requested together
  a_r3_one_ptr_op: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.subLoad && ctl.addrInc));

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic [6:0]        ownAddr,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [7:0]        dbgData
);

  localparam int DW = 8;

  logic sclLvl, sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic addrHit, rwBit, txMsb;
  dp_ctl_t ctl;

  i2c_mem_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2c_mem_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaLvl(sdaLvl),
    .addrHit(addrHit), .rwBit(rwBit), .txMsb(txMsb),
    .ctl(ctl), .sdaPullLow(sdaPullLow)
  );

  i2c_mem_dp #(.ADDR_W(ADDR_W), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaLvl(sdaLvl), .ownAddr(ownAddr),
    .dbgAddr(dbgAddr), .addrHit(addrHit), .rwBit(rwBit), .txMsb(txMsb),
    .dbgData(dbgData)
  );

  // R9: drive changes only with SCL low (or when a start/stop releases it)
  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclLvl || $past(startSeen || stopSeen));

endmodule

// File: tb/i2c_mem_target_bench.sv
module i2c_mem_target_bench;

  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h52;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mLow = 1'b0;
  logic sLow;
  logic [7:0] dbgAddr = '0;
  logic [7:0] dbgData;
  wire  sdaBus = !(mLow | sLow);

  int nChecks = 0;
  int nFail = 0;
  int r9Viol = 0;
  bit done = 0;

  logic [7:0] model [256];
  logic [7:0] wbuf [8];
  logic [7:0] mAddr;

  always #10 clk = ~clk;

  i2c_mem_target u_i2c_mem_target (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .sdaPullLow(sLow), .ownAddr(DEV), .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  // R9 monitor: target drive may only change while SCL is low
  logic sLowLast = 1'b0;
  logic sclLast = 1'b1;
  always @(negedge clk) begin
    if (rstN && sLow !== sLowLast && sclLast) r9Viol++;
    sLowLast = sLow;
    sclLast  = mScl;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mLow = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mLow = 1'b1; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mLow = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mLow = 1'b0; waitQ();
  endtask

  task automatic busBit(input logic b, output logic s);
    mLow = !b; waitQ();
    mScl = 1'b1; waitQ();
    s = sdaBus;
    mScl = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) busBit(b[i], s);
    busBit(1'b1, s);
    acked = !s;
  endtask

  task automatic readByte(output logic [7:0] d, input logic giveAck);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      busBit(1'b1, s);
      d[i] = s;
    end
    busBit(!giveAck, s);
  endtask

  task automatic doWrite(input logic [7:0] sub, input int n);
    logic a;
    busStart();
    writeByte({DEV, 1'b0}, a); check("R2 write address ack", a, 1);
    writeByte(sub, a);         check("R3 pointer byte ack", a, 1);
    mAddr = sub;
    for (int i = 0; i < n; i++) begin
      writeByte(wbuf[i], a);   check("R4 data byte ack", a, 1);
      model[mAddr] = wbuf[i];
      mAddr = mAddr + 8'd1;
    end
    busStop();
    for (int i = 0; i < n; i++) begin
      dbgAddr = sub + 8'(i);
      @(negedge clk);
      check("R10 R4 stored byte", dbgData, model[dbgAddr]);
    end
  endtask

  task automatic doRead(input logic [7:0] sub, input int n);
    logic a;
    logic [7:0] d;
    busStart();
    writeByte({DEV, 1'b0}, a); check("R2 write address ack", a, 1);
    writeByte(sub, a);         check("R3 pointer byte ack", a, 1);
    mAddr = sub;
    busStart();
    writeByte({DEV, 1'b1}, a); check("R2 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      readByte(d, i != n - 1);
      check("R6 read data", d, model[mAddr]);
      mAddr = mAddr + 8'd1;
    end
    busStop();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic a;
    logic s;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    check("R11 SDA released in reset", sLow, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 SDA released after reset", sLow, 0);

    // R5 wrap on write and read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    doWrite(8'hFE, 3);
    dbgAddr = 8'h00; @(negedge clk);
    check("R5 write wrapped to 0", dbgData, 8'h33);
    doRead(8'hFE, 3);

    // R7 negative acknowledge then extra clocks read released bus
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h0F; wbuf[3] = 8'hE1;
    doWrite(8'h10, 4);
    doRead(8'h10, 1);
    busStart();
    writeByte({DEV, 1'b0}, a);
    writeByte(8'h10, a);
    busStart();
    writeByte({DEV, 1'b1}, a);
    readByte(d, 1'b0);
    check("R7 last byte before nack", d, 8'hA5);
    readByte(d, 1'b0);
    check("R7 bus released after nack", d, 8'hFF);
    busStop();

    // R8 pointer kept across stop: read without pointer byte continues at 0x11
    busStart();
    writeByte({DEV, 1'b1}, a); check("R8 read address ack", a, 1);
    readByte(d, 1'b0);
    check("R8 pointer kept across stop", d, 8'h3C);
    busStop();

    // R2 mismatched address: no ack, no write, pointer untouched (now 0x12)
    busStart();
    writeByte({DEV ^ 7'h01, 1'b0}, a); check("R2 mismatch no ack", a, 0);
    writeByte(8'h10, a);               check("R2 mismatch byte ignored", a, 0);
    writeByte(8'h99, a);               check("R2 mismatch data ignored", a, 0);
    busStop();
    dbgAddr = 8'h10; @(negedge clk);
    check("R2 memory unchanged", dbgData, 8'hA5);
    busStart();
    writeByte({DEV ^ 7'h40, 1'b1}, a); check("R2 mismatch read no ack", a, 0);
    busStop();
    busStart();
    writeByte({DEV, 1'b1}, a);
    readByte(d, 1'b0);
    check("R2 pointer unchanged by mismatch", d, 8'h0F);
    busStop();

    // R1 start in the middle of an address byte
    busStart();
    for (int i = 7; i >= 4; i--) busBit(DEV[i-1], s);
    busStart();
    writeByte({DEV, 1'b0}, a); check("R1 address after restart", a, 1);
    writeByte(8'h40, a);
    writeByte(8'h5A, a);       check("R1 data after restart", a, 1);
    busStop();
    model[8'h40] = 8'h5A;
    dbgAddr = 8'h40; @(negedge clk);
    check("R1 byte stored after restart", dbgData, 8'h5A);

    // random bursts
    for (int t = 0; t < 14; t++) begin
      logic [7:0] sub;
      int n;
      sub = 8'($urandom);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      doWrite(sub, n);
      doRead(sub, n);
    end

    check("R9 drive changed only with SCL low", r9Viol, 0);
    finishRun();
  end

endmodule